// File: doc/BRIEF.md
# Protocol Control Microsequencer

This block is the small microcoded engine that steps a token-passing network controller through its control program. A read-only program store holds two-byte instructions. The sequencer fetches one byte per fast clock. The opcode byte is taken in the cycle where the half-rate execute enable is high, and the immediate byte is taken in the cycle after it. Each complete instruction then acts in the next execute slot. An instruction can do one of three things: emit a word of control strobes together with its immediate data, stall the fetch for a counted number of execute slots, or redirect the program counter to a target taken from the instruction itself.

An external reconfiguration timer can interrupt the program at any fast cycle. When it does, the sequencer throws away any partly fetched or pending instruction and any running delay. The program restarts from address zero and a sticky status flag is raised. The flag stays up until a clear strobe or a reset removes it. The program in the store is a short illustrative routine computed inside the design; the real protocol microcode, the network datapath and the host registers are outside this block.

Top module: `tp_microseq`

## Requirements
- R1: Fetch timing. The opcode byte at the program counter is latched on a clock edge where `exec_en_i` is high. The immediate byte at the next address is latched on the following edge where it is low. The instruction acts on the next edge where `exec_en_i` is high. Instructions that do not stall the fetch run back to back, one per execute slot.
- R2: Opcode encoding. Bit 7 set means jump. Otherwise bit 6 set means wait. Otherwise the instruction is a control instruction: it drives opcode bits [5:0] on `ctl_strobe_o` and its immediate byte on `ctl_data_o`.
- R3: Control strobes change only on execute edges or on a timeout. A control instruction's strobes stay up for exactly one execute period (two fast cycles). Strobes are zero after any execute edge that does not run a control instruction.
- R4: A jump loads the program counter with {opcode[1:0], immediate}, or with zero if that value is beyond the last store address. It does not fetch in its own execute slot, so the target instruction acts two slots after the jump.
- R5: A wait with immediate N skips the opcode fetch in N execute slots, counting from its own slot, and holds the program counter meanwhile. N = 0 adds no delay.
- R6: Stepping past the last store address (STORE_DEPTH-1) wraps the program counter to zero.
- R7: A pulse on `recon_tmo_i` clears the program counter, drops any fetched, pending or waiting instruction and zeroes the strobes on the same edge. The next execute slot fetches address 0, and the slot after that runs the instruction stored there.
- R8: A timeout takes priority over a jump that executes on the same edge.
- R9: `recon_flag_o` is set by a timeout and stays set until `recon_clr_i` is pulsed. A timeout and a clear on the same edge leave the flag set.
- R10: Synchronous reset `rst_i` zeroes the strobes, the data output, the flag, the counter, both instruction registers and the wait count. The program then restarts as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock (fetch rate) |
| rst_i | input | 1 | Synchronous active-high reset |
| exec_en_i | input | 1 | Half-rate execute enable, high on alternate cycles |
| recon_tmo_i | input | 1 | Reconfiguration timeout pulse |
| recon_clr_i | input | 1 | Clear strobe for the reconfiguration flag |
| ctl_strobe_o | output | 6 | Control strobes of the executing instruction |
| ctl_data_o | output | 8 | Immediate data of the last control instruction |
| recon_flag_o | output | 1 | Sticky reconfiguration status |

## Verification
The checker watches every cycle for the local rules. It confirms that the counter stays inside the store and that it freezes while a wait is counting. It checks that a jump lands on its legalised target, that a control instruction's strobes equal its opcode bits, that strobes hold between execute edges, and how the flag is set, held and cleared. Only the bench scenarios can show the whole-program timing. That covers the exact execute slot of each strobe word after waits of three and of zero slots, after a jump and after the wrap from the last address. It also covers restarts after timeouts that land on a jump slot and in the middle of a wait.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int WORD_W   = 8;
    localparam int JUMP_BIT = 7;
    localparam int WAIT_BIT = 6;
    localparam int STB_W    = 6;
    localparam int TGT_HI_W = 2;

    typedef enum logic [1:0] {
        K_CTRL = 2'd0,
        K_WAIT = 2'd1,
        K_JUMP = 2'd2
    } kind_e;

endpackage

// File: rtl/useq_store.sv
module useq_store #(
    parameter int DEPTH = 544,
    parameter int AW    = 10
) (
    input  logic [AW-1:0] addr_i,
    output logic [7:0]    word_o
);

    // Illustrative routine: two ctrl, wait 3, ctrl, wait 0, ctrl, jump to
    // the last two instructions of the store, which fall through to zero.
    localparam int TGT = DEPTH - 4;

    function automatic logic [7:0] prog_word(input int a);
        logic [7:0] w;
        w = 8'h00;
        case (a)
            0:  w = 8'h01;
            1:  w = 8'h11;
            2:  w = 8'h02;
            3:  w = 8'h22;
            4:  w = 8'h40;
            5:  w = 8'h03;
            6:  w = 8'h04;
            7:  w = 8'h33;
            8:  w = 8'h40;
            9:  w = 8'h00;
            10: w = 8'h08;
            11: w = 8'h44;
            12: w = 8'h80 | 8'((TGT >> 8) & 3);
            13: w = 8'(TGT & 255);
            default: w = 8'h00;
        endcase
        if (a == DEPTH - 4) w = 8'h10;
        if (a == DEPTH - 3) w = 8'h66;
        if (a == DEPTH - 2) w = 8'h20;
        if (a == DEPTH - 1) w = 8'h5A;
        return w;
    endfunction

    always_comb begin
        word_o = prog_word(int'(addr_i));
    end

endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic [WORD_W-1:0] op_i,
    input  logic [WORD_W-1:0] imm_i,
    output kind_e             kind_o,
    output logic [STB_W-1:0]  stb_o,
    output logic [AW-1:0]     tgt_o,
    output logic [WORD_W-1:0] delay_o
);

    always_comb begin
        if (op_i[JUMP_BIT])      kind_o = K_JUMP;
        else if (op_i[WAIT_BIT]) kind_o = K_WAIT;
        else                     kind_o = K_CTRL;
        stb_o   = op_i[STB_W-1:0];
        tgt_o   = AW'({op_i[TGT_HI_W-1:0], imm_i});
        delay_o = imm_i;
    end

endmodule

// File: rtl/useq_pcstep.sv
module useq_pcstep #(
    parameter int DEPTH = 544,
    parameter int AW    = 10
) (
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] tgt_i,
    output logic [AW-1:0] inc_o,
    output logic [AW-1:0] tgt_ok_o
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_comb begin
        inc_o    = (pc_i == LAST) ? '0 : pc_i + 1'b1;
        tgt_ok_o = (tgt_i <= LAST) ? tgt_i : '0;
    end

endmodule

// File: rtl/tp_microseq.sv
module tp_microseq
    import useq_pkg::*;
#(
    parameter int STORE_DEPTH = 544
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              exec_en_i,
    input  logic              recon_tmo_i,
    input  logic              recon_clr_i,
    output logic [STB_W-1:0]  ctl_strobe_o,
    output logic [WORD_W-1:0] ctl_data_o,
    output logic              recon_flag_o
);

    localparam int PC_W   = $clog2(STORE_DEPTH);
    localparam int WAIT_W = WORD_W;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [WORD_W-1:0] op;
        logic [WORD_W-1:0] imm;
        logic              have_op;
        logic              pend;
        logic [WAIT_W-1:0] wait_cnt;
        logic [STB_W-1:0]  strb;
        logic [WORD_W-1:0] data;
        logic              flag;
    } seq_t;

    seq_t s_d, s_q;

    logic [WORD_W-1:0] word;
    kind_e             kind;
    logic [STB_W-1:0]  stb;
    logic [PC_W-1:0]   tgt_raw;
    logic [PC_W-1:0]   tgt_ok;
    logic [PC_W-1:0]   pc_inc;
    logic [WORD_W-1:0] delay;
    logic              fetch_now;

    useq_store #(.DEPTH(STORE_DEPTH), .AW(PC_W)) u_store (
        .addr_i (s_q.pc),
        .word_o (word)
    );

    useq_decode #(.AW(PC_W)) u_dec (
        .op_i    (s_q.op),
        .imm_i   (s_q.imm),
        .kind_o  (kind),
        .stb_o   (stb),
        .tgt_o   (tgt_raw),
        .delay_o (delay)
    );

    useq_pcstep #(.DEPTH(STORE_DEPTH), .AW(PC_W)) u_step (
        .pc_i     (s_q.pc),
        .tgt_i    (tgt_raw),
        .inc_o    (pc_inc),
        .tgt_ok_o (tgt_ok)
    );

    always_comb begin
        s_d       = s_q;
        fetch_now = 1'b0;
        if (exec_en_i) begin
            s_d.strb  = '0;
            s_d.pend  = 1'b0;
            fetch_now = 1'b1;
            if (s_q.wait_cnt != '0) begin
                s_d.wait_cnt = s_q.wait_cnt - 1'b1;
                fetch_now    = 1'b0;
            end else if (s_q.pend) begin
                unique case (kind)
                    K_JUMP: begin
                        s_d.pc    = tgt_ok;
                        fetch_now = 1'b0;
                    end
                    K_WAIT: begin
                        if (delay != '0) begin
                            s_d.wait_cnt = delay - 1'b1;
                            fetch_now    = 1'b0;
                        end
                    end
                    default: begin
                        s_d.strb = stb;
                        s_d.data = s_q.imm;
                    end
                endcase
            end
            if (fetch_now) begin
                s_d.op      = word;
                s_d.have_op = 1'b1;
                s_d.pc      = pc_inc;
            end
        end else if (s_q.have_op) begin
            s_d.imm     = word;
            s_d.have_op = 1'b0;
            s_d.pend    = 1'b1;
            s_d.pc      = pc_inc;
        end

        if (recon_tmo_i) begin
            s_d.pc       = '0;
            s_d.have_op  = 1'b0;
            s_d.pend     = 1'b0;
            s_d.wait_cnt = '0;
            s_d.strb     = '0;
            s_d.flag     = 1'b1;
        end else if (recon_clr_i) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign ctl_strobe_o = s_q.strb;
    assign ctl_data_o   = s_q.data;
    assign recon_flag_o = s_q.flag;

    logic [PC_W-1:0]   pc_mon;
    logic [WORD_W-1:0] op_mon;
    logic [WORD_W-1:0] imm_mon;
    logic              pend_mon;
    logic              wait_mon;

    assign pc_mon   = s_q.pc;
    assign op_mon   = s_q.op;
    assign imm_mon  = s_q.imm;
    assign pend_mon = s_q.pend;
    assign wait_mon = (s_q.wait_cnt != '0);

endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
    parameter int DEPTH = 544,
    parameter int AW    = 10
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          exec_en_i,
    input logic          recon_tmo_i,
    input logic          recon_clr_i,
    input logic [5:0]    strobe_i,
    input logic          flag_i,
    input logic [AW-1:0] pc_i,
    input logic [7:0]    op_i,
    input logic [7:0]    imm_i,
    input logic          pend_i,
    input logic          wait_i
);

    logic [AW-1:0] raw_tgt;
    logic [AW-1:0] exp_tgt;

    assign raw_tgt = AW'({op_i[1:0], imm_i});
    assign exp_tgt = (int'(raw_tgt) < DEPTH) ? raw_tgt : '0;

    // R6
    always @(posedge clk_i) begin
        if (!rst_i) begin
            pc_in_store_chk: assert (int'(pc_i) < DEPTH)
                else $error("counter left the store");
        end
    end

    // R3
    strobe_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!exec_en_i && !recon_tmo_i) |=> $stable(strobe_i));

    // R2
    ctrl_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (exec_en_i && pend_i && !op_i[7] && !op_i[6] && !recon_tmo_i)
        |=> (strobe_i == $past(op_i[5:0])));

    // R4
    jump_target_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (exec_en_i && pend_i && op_i[7] && !recon_tmo_i)
        |=> (pc_i == $past(exp_tgt)));

    // R5
    wait_freeze_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wait_i && !recon_tmo_i) |=> $stable(pc_i));

    // R7
    recon_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        recon_tmo_i |=> (pc_i == '0 && strobe_i == '0 && !pend_i && !wait_i));

    // R9
    flag_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        recon_tmo_i |=> flag_i);

    // R9
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (flag_i && !recon_clr_i) |=> flag_i);

    // R9
    flag_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (recon_clr_i && !recon_tmo_i) |=> !flag_i);

endmodule

bind tp_microseq useq_chk #(.DEPTH(STORE_DEPTH), .AW(PC_W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .exec_en_i   (exec_en_i),
    .recon_tmo_i (recon_tmo_i),
    .recon_clr_i (recon_clr_i),
    .strobe_i    (ctl_strobe_o),
    .flag_i      (recon_flag_o),
    .pc_i        (pc_mon),
    .op_i        (op_mon),
    .imm_i       (imm_mon),
    .pend_i      (pend_mon),
    .wait_i      (wait_mon)
);

// File: tb/tp_microseq_test.sv
module tp_microseq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exec_en = 1'b0;
    logic       recon = 1'b0;
    logic       clr = 1'b0;
    logic [5:0] strobe;
    logic [7:0] data;
    logic       flag;

    always #4 clk = ~clk;
    always @(negedge clk) exec_en <= ~exec_en;

    tp_microseq uut (
        .clk_i        (clk),
        .rst_i        (rst),
        .exec_en_i    (exec_en),
        .recon_tmo_i  (recon),
        .recon_clr_i  (clr),
        .ctl_strobe_o (strobe),
        .ctl_data_o   (data),
        .recon_flag_o (flag)
    );

    typedef struct {
        int         slot;
        logic [5:0] stb;
        logic [7:0] dat;
        string      req;
    } exp_t;

    exp_t q[$];
    int   rd_idx = 0;
    int   slot_cnt = 0;
    bit   mon_on = 1'b0;
    int   mon_vec = 0, mon_err = 0;
    int   drv_vec = 0, drv_err = 0;
    logic [5:0] last_stb = '0;

    // Program as seen at the strobe outputs: slot offset after restart.
    int         offs[6] = '{1, 2, 7, 9, 12, 13};
    logic [5:0] stbs[6] = '{6'h01, 6'h02, 6'h04, 6'h08, 6'h10, 6'h20};
    logic [7:0] dats[6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h66, 8'h5A};
    string      tags[6] = '{"R1", "R1", "R5", "R5", "R4", "R2"};

    task automatic push_run(input int base, input int stop, input string first_tag);
        for (int p = 0; base + 13 * p < stop; p++) begin
            for (int i = 0; i < 6; i++) begin
                exp_t e;
                e.slot = base + offs[i] + 13 * p;
                e.stb  = stbs[i];
                e.dat  = dats[i];
                e.req  = tags[i];
                if (i == 0) e.req = (p == 0) ? first_tag : "R6";
                if (e.slot < stop) q.push_back(e);
            end
        end
    endtask

    // Monitor: pops expected strobe words in slot order.
    always @(posedge clk) begin
        #1;
        if (rst) begin
            slot_cnt = 0;
            last_stb = '0;
        end else if (exec_en) begin
            if (mon_on) begin
                if (strobe != '0) begin
                    mon_vec++;
                    if (rd_idx >= q.size()) begin
                        mon_err++;
                        $display("FAIL R3 slot %0d: actual strobe %0h, expected none", slot_cnt, strobe);
                    end else begin
                        if (q[rd_idx].slot != slot_cnt || q[rd_idx].stb != strobe || q[rd_idx].dat != data) begin
                            mon_err++;
                            $display("FAIL %s: actual slot %0d stb %0h data %0h, expected slot %0d stb %0h data %0h",
                                     q[rd_idx].req, slot_cnt, strobe, data,
                                     q[rd_idx].slot, q[rd_idx].stb, q[rd_idx].dat);
                        end
                        rd_idx++;
                    end
                end else if (rd_idx < q.size() && q[rd_idx].slot == slot_cnt) begin
                    mon_vec++;
                    mon_err++;
                    $display("FAIL %s slot %0d: actual stb 0, expected stb %0h",
                             q[rd_idx].req, slot_cnt, q[rd_idx].stb);
                    rd_idx++;
                end
            end
            last_stb = strobe;
            slot_cnt++;
        end else if (mon_on && !recon) begin
            mon_vec++;
            if (strobe != last_stb) begin
                mon_err++;
                $display("FAIL R3 hold: actual %0h expected %0h", strobe, last_stb);
            end
        end
    end

    task automatic dcheck(input bit ok, input string req, input string what, input int act, input int expv);
        drv_vec++;
        if (!ok) begin
            drv_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_before_slot(input int s);
        do tick(); while (!(exec_en && slot_cnt == s));
    endtask

    task automatic wait_after_slot(input int s);
        do tick(); while (!(!exec_en && slot_cnt == s + 1));
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", mon_vec + drv_vec, mon_err + drv_err);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        drv_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) tick();
        // R10: reset state
        dcheck(strobe == 0, "R10", "strobe in reset", strobe, 0);
        dcheck(data == 0, "R10", "data in reset", data, 0);
        dcheck(flag == 0, "R10", "flag in reset", flag, 0);

        // R1 R2 R4 R5 R6: first run of the program
        push_run(0, 23, "R1");
        mon_on = 1'b1;
        rst = 1'b0;

        // R8: timeout on the slot where the jump executes
        wait_before_slot(23);
        push_run(24, 29, "R8");
        recon = 1'b1;
        tick();
        recon = 1'b0;
        dcheck(strobe == 0, "R7", "strobe after timeout", strobe, 0);
        dcheck(flag == 1, "R9", "flag after timeout", flag, 1);

        // R7: timeout in a fetch cycle while a wait is counting
        wait_after_slot(28);
        push_run(29, 60, "R7");
        recon = 1'b1;
        tick();
        recon = 1'b0;
        repeat (6) tick();
        dcheck(flag == 1, "R9", "flag sticky", flag, 1);

        wait_before_slot(60);
        mon_on = 1'b0;
        dcheck(rd_idx == q.size(), "R1", "expected words left", q.size() - rd_idx, 0);

        // R9: clear, then timeout and clear together
        clr = 1'b1;
        tick();
        clr = 1'b0;
        dcheck(flag == 0, "R9", "flag cleared", flag, 0);
        recon = 1'b1;
        clr = 1'b1;
        tick();
        recon = 1'b0;
        clr = 1'b0;
        dcheck(flag == 1, "R9", "timeout beats clear", flag, 1);
        dcheck(strobe == 0, "R7", "strobe zero after timeout", strobe, 0);

        // R10: reset in mid-run clears the flag and restarts
        repeat (5) tick();
        rst = 1'b1;
        repeat (3) tick();
        dcheck(flag == 0, "R10", "flag after reset", flag, 0);
        dcheck(strobe == 0, "R10", "strobe after reset", strobe, 0);
        dcheck(data == 0, "R10", "data after reset", data, 0);
        q.delete();
        rd_idx = 0;
        push_run(0, 15, "R10");
        mon_on = 1'b1;
        rst = 1'b0;
        wait_before_slot(15);
        mon_on = 1'b0;
        dcheck(rd_idx == q.size(), "R10", "words after restart", q.size() - rd_idx, 0);

        finish_run();
    end

endmodule